// File: doc/BRIEF.md
# Dependency-Driven Issue FIFO Steering

This block sits at the dispatch stage of an out-of-order core whose issue queue is a set of in-order FIFOs, of which only the heads compete for issue. For each instruction offered, it picks the FIFO to append to in the same cycle. The aim is to queue a consumer directly behind the instruction that produces one of its operands, so that each FIFO holds a dependence chain. Then the entry at each head is the one most likely to be ready. An instruction with no pending operand, or whose producer cannot be followed, gets a fresh empty FIFO. When no FIFO is possible, the block raises stall and the dispatcher offers the same instruction again next cycle.

A table indexed by destination register records which FIFO holds each register's producer while that producer is still the FIFO's last entry. A record is dropped when its producer issues or when anything is appended behind it. For an instruction with two pending operands, a table of 2-bit saturating counters indexed by the low PC bits predicts which operand will arrive later. That producer's FIFO is tried first, then the other producer's FIFO, then an empty FIFO. The counters are trained from outside with the source that actually woke up last.

There is no sequential control state. Each offer falls into one of four decision classes held in an enumerated type: `MODE_IDLE` (nothing offered), `MODE_ALLRDY` (both sources ready), `MODE_ONE` (exactly one source pending) and `MODE_TWO` (both pending). The class is chosen afresh from the inputs each cycle, and any class can follow any other. The only stored state is the producer table and the counter table.

Top module: `steer_unit`

## Requirements
- R1: When both sources are ready, the chosen FIFO is the lowest-index FIFO that is both enabled and empty.
- R2: With exactly one pending source whose producer is recorded as the tail of an enabled, non-full FIFO, that FIFO is chosen.
- R3: With exactly one pending source whose producer cannot be followed (not recorded, disabled or full), the lowest-index enabled empty FIFO is chosen.
- R4: With two pending sources, the producer of the source predicted to arrive later is tried first; a counter value of 2 or 3 predicts source 2, and 0 or 1 predicts source 1.
- R5: With two pending sources, if the first producer cannot be followed, the other producer's FIFO is chosen if followable, else the lowest-index enabled empty FIFO.
- R6: When an instruction is offered and no candidate exists, `stall` is 1 and `steer_valid` is 0, and no table is changed by that offer. With nothing offered, both outputs are 0.
- R7: After a successful dispatch to FIFO k, the destination register becomes the recorded tail of k, and any register previously recorded as tail of k is no longer followable.
- R8: An issue notice for a register removes its producer record; a dispatch writing the same register in the same cycle takes precedence.
- R9: After reset, no register has a producer record and every predictor counter is 1. Training moves a counter up (source 2 was last) or down (source 1 was last), saturating at 3 and 0.
- R10: A FIFO whose enable bit is 0 is never chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_valid | input | 1 | An instruction is offered this cycle |
| disp_pc | input | PC_W | PC of the offered instruction |
| src1_reg | input | REG_W | First source register |
| src1_rdy | input | 1 | First source value is available |
| src2_reg | input | REG_W | Second source register |
| src2_rdy | input | 1 | Second source value is available |
| dst_reg | input | REG_W | Destination register |
| fifo_en | input | NUM_FIFO | Per-FIFO enable |
| fifo_empty | input | NUM_FIFO | Per-FIFO empty status |
| fifo_full | input | NUM_FIFO | Per-FIFO full status |
| iss_valid | input | 1 | A producer issued this cycle |
| iss_reg | input | REG_W | Destination register of the issued producer |
| lop_train | input | 1 | Predictor training strobe |
| lop_pc | input | PC_W | PC of the training instruction |
| lop_src2_last | input | 1 | 1 if source 2 woke last, 0 if source 1 |
| steer_valid | output | 1 | Instruction accepted into `steer_fifo` |
| steer_fifo | output | FIFO_W | Chosen FIFO index |
| stall | output | 1 | Offer refused; retry next cycle |

## Verification
The all-ready class is swept over every combination of enable and empty masks. This separates the lowest-index priority from any other order, and it also shows that disabled FIFOs are skipped. Directed chains then build producers in chosen FIFOs and check three things: following a tail, losing a tail when something is appended behind it, and losing it on issue. Two-pending offers are run before and after the counter is trained, to tell the predicted order from a fixed one, and with one producer gone, to expose the fallback order. A long pseudo-random stream over a few registers mixes issue notices, training, full FIFOs and stalls, and is compared each cycle against an arithmetic model of the rules.

// File: rtl/steer_pkg.sv
package steer_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_ALLRDY,
        MODE_ONE,
        MODE_TWO
    } steer_mode_e;

    localparam logic [1:0] LOP_INIT = 2'b01;
endpackage

// File: rtl/steer_ptab.sv
module steer_ptab #(
    parameter int NUM_FIFO = 4,
    parameter int NUM_REG  = 16,
    localparam int FIFO_W = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1,
    localparam int REG_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  rd_a,
    input  logic [REG_W-1:0]  rd_b,
    output logic              hit_a,
    output logic [FIFO_W-1:0] loc_a,
    output logic              hit_b,
    output logic [FIFO_W-1:0] loc_b,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic [FIFO_W-1:0] wr_fifo,
    input  logic              kill_en,
    input  logic [REG_W-1:0]  kill_reg
);
    logic [NUM_REG-1:0] live;
    logic [FIFO_W-1:0]  where [NUM_REG];

    for (genvar r = 0; r < NUM_REG; r++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live[r]  <= 1'b0;
                where[r] <= '0;
            end else if (wr_en && wr_reg == REG_W'(r)) begin
                live[r]  <= 1'b1;
                where[r] <= wr_fifo;
            end else if (wr_en && live[r] && where[r] == wr_fifo) begin
                live[r] <= 1'b0;
            end else if (kill_en && kill_reg == REG_W'(r)) begin
                live[r] <= 1'b0;
            end
        end
    end

    assign hit_a = live[rd_a];
    assign loc_a = where[rd_a];
    assign hit_b = live[rd_b];
    assign loc_b = where[rd_b];
endmodule

// File: rtl/steer_lop.sv
module steer_lop
    import steer_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 16,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] rd_pc,
    output logic            late_is_src2,
    input  logic            trn_en,
    input  logic [PC_W-1:0] trn_pc,
    input  logic            trn_src2_last
);
    logic [1:0] ctr [ENTRIES];
    logic [IDX_W-1:0] rd_idx, trn_idx;

    assign rd_idx  = rd_pc[IDX_W-1:0];
    assign trn_idx = trn_pc[IDX_W-1:0];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ctr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctr[e] <= LOP_INIT;
            end else if (trn_en && trn_idx == IDX_W'(e)) begin
                if (trn_src2_last && ctr[e] != 2'b11)
                    ctr[e] <= ctr[e] + 2'b01;
                else if (!trn_src2_last && ctr[e] != 2'b00)
                    ctr[e] <= ctr[e] - 2'b01;
            end
        end
    end

    assign late_is_src2 = ctr[rd_idx][1];
endmodule

// File: rtl/steer_pick.sv
module steer_pick #(
    parameter int NUM_FIFO = 4,
    localparam int FIFO_W = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
    input  logic                first_ok,
    input  logic [FIFO_W-1:0]   first_fifo,
    input  logic                second_ok,
    input  logic [FIFO_W-1:0]   second_fifo,
    input  logic [NUM_FIFO-1:0] fifo_en,
    input  logic [NUM_FIFO-1:0] fifo_empty,
    input  logic [NUM_FIFO-1:0] fifo_full,
    output logic                found,
    output logic [FIFO_W-1:0]   choice
);
    logic              first_go, second_go, fresh_ok;
    logic [FIFO_W-1:0] fresh_idx;

    always_comb begin
        fresh_ok  = 1'b0;
        fresh_idx = '0;
        for (int i = NUM_FIFO - 1; i >= 0; i--) begin
            if (fifo_en[i] && fifo_empty[i]) begin
                fresh_ok  = 1'b1;
                fresh_idx = FIFO_W'(i);
            end
        end
    end

    assign first_go  = first_ok  && fifo_en[first_fifo]  && !fifo_full[first_fifo];
    assign second_go = second_ok && fifo_en[second_fifo] && !fifo_full[second_fifo];

    always_comb begin
        found  = 1'b1;
        choice = fresh_idx;
        if (first_go)       choice = first_fifo;
        else if (second_go) choice = second_fifo;
        else if (!fresh_ok) found  = 1'b0;
    end
endmodule

// File: rtl/steer_unit.sv
module steer_unit
    import steer_pkg::*;
#(
    parameter int NUM_FIFO    = 4,
    parameter int NUM_REG     = 16,
    parameter int LOP_ENTRIES = 16,
    parameter int PC_W        = 16,
    localparam int FIFO_W = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1,
    localparam int REG_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                disp_valid,
    input  logic [PC_W-1:0]     disp_pc,
    input  logic [REG_W-1:0]    src1_reg,
    input  logic                src1_rdy,
    input  logic [REG_W-1:0]    src2_reg,
    input  logic                src2_rdy,
    input  logic [REG_W-1:0]    dst_reg,
    input  logic [NUM_FIFO-1:0] fifo_en,
    input  logic [NUM_FIFO-1:0] fifo_empty,
    input  logic [NUM_FIFO-1:0] fifo_full,
    input  logic                iss_valid,
    input  logic [REG_W-1:0]    iss_reg,
    input  logic                lop_train,
    input  logic [PC_W-1:0]     lop_pc,
    input  logic                lop_src2_last,
    output logic                steer_valid,
    output logic [FIFO_W-1:0]   steer_fifo,
    output logic                stall
);
    steer_mode_e       mode;
    logic              hit1, hit2, late2, found;
    logic [FIFO_W-1:0] loc1, loc2;
    logic              c1_ok, c2_ok;
    logic [FIFO_W-1:0] c1_fifo, c2_fifo;

    steer_ptab #(.NUM_FIFO(NUM_FIFO), .NUM_REG(NUM_REG)) u_ptab (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a     (src1_reg),
        .rd_b     (src2_reg),
        .hit_a    (hit1),
        .loc_a    (loc1),
        .hit_b    (hit2),
        .loc_b    (loc2),
        .wr_en    (steer_valid),
        .wr_reg   (dst_reg),
        .wr_fifo  (steer_fifo),
        .kill_en  (iss_valid),
        .kill_reg (iss_reg)
    );

    steer_lop #(.ENTRIES(LOP_ENTRIES), .PC_W(PC_W)) u_lop (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_pc         (disp_pc),
        .late_is_src2  (late2),
        .trn_en        (lop_train),
        .trn_pc        (lop_pc),
        .trn_src2_last (lop_src2_last)
    );

    always_comb begin
        if (!disp_valid)              mode = MODE_IDLE;
        else if (src1_rdy && src2_rdy) mode = MODE_ALLRDY;
        else if (src1_rdy || src2_rdy) mode = MODE_ONE;
        else                           mode = MODE_TWO;
    end

    always_comb begin
        c1_ok   = 1'b0;
        c1_fifo = '0;
        c2_ok   = 1'b0;
        c2_fifo = '0;
        unique case (mode)
            MODE_IDLE, MODE_ALLRDY: ;
            MODE_ONE: begin
                c1_ok   = src1_rdy ? hit2 : hit1;
                c1_fifo = src1_rdy ? loc2 : loc1;
            end
            MODE_TWO: begin
                c1_ok   = late2 ? hit2 : hit1;
                c1_fifo = late2 ? loc2 : loc1;
                c2_ok   = late2 ? hit1 : hit2;
                c2_fifo = late2 ? loc1 : loc2;
            end
            default: ;
        endcase
    end

    steer_pick #(.NUM_FIFO(NUM_FIFO)) u_pick (
        .first_ok    (c1_ok),
        .first_fifo  (c1_fifo),
        .second_ok   (c2_ok),
        .second_fifo (c2_fifo),
        .fifo_en     (fifo_en),
        .fifo_empty  (fifo_empty),
        .fifo_full   (fifo_full),
        .found       (found),
        .choice      (steer_fifo)
    );

    assign steer_valid = (mode != MODE_IDLE) && found;
    assign stall       = (mode != MODE_IDLE) && !found;
endmodule

// File: rtl/steer_unit_chk.sv
module steer_unit_chk #(
    parameter int NUM_FIFO = 4,
    parameter int FIFO_W   = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                disp_valid,
    input logic                src1_rdy,
    input logic                src2_rdy,
    input logic [NUM_FIFO-1:0] fifo_en,
    input logic [NUM_FIFO-1:0] fifo_empty,
    input logic [NUM_FIFO-1:0] fifo_full,
    input logic                steer_valid,
    input logic [FIFO_W-1:0]   steer_fifo,
    input logic                stall
);
    AST_TARGET_USABLE: assert property (@(posedge clk) disable iff (!rst_n)
        steer_valid |-> (fifo_en[steer_fifo] && !fifo_full[steer_fifo])); // R10
    AST_READY_TO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_valid && src1_rdy && src2_rdy) |-> fifo_empty[steer_fifo]); // R1
    AST_STALL_NO_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ((fifo_en & fifo_empty) == '0)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_valid |-> (!steer_valid && !stall)); // R6
    AST_OFFER_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> $countones({steer_valid, stall}) == 1); // R6
endmodule

bind steer_unit steer_unit_chk #(.NUM_FIFO(NUM_FIFO), .FIFO_W(FIFO_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_valid  (disp_valid),
    .src1_rdy    (src1_rdy),
    .src2_rdy    (src2_rdy),
    .fifo_en     (fifo_en),
    .fifo_empty  (fifo_empty),
    .fifo_full   (fifo_full),
    .steer_valid (steer_valid),
    .steer_fifo  (steer_fifo),
    .stall       (stall)
);

// File: tb/steer_unit_tb.sv
module steer_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        d_valid = 0, r1 = 1, r2 = 1, iv = 0, tv = 0, tl2 = 0;
    logic [15:0] d_pc = 0, tpc = 0;
    logic [3:0]  s1 = 0, s2 = 0, dst = 0, idst = 0;
    logic [3:0]  en = 4'hF, emp = 4'hF, full = 4'h0;
    logic        steer_valid, stall;
    logic [1:0]  steer_fifo;

    int total = 0, bad = 0;
    bit mv [16];
    int mf [16];
    int mc [16];
    bit m_ok;
    int m_f;
    logic [31:0] rs = 32'h1234_5678;

    steer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .disp_valid(d_valid), .disp_pc(d_pc),
        .src1_reg(s1), .src1_rdy(r1), .src2_reg(s2), .src2_rdy(r2), .dst_reg(dst),
        .fifo_en(en), .fifo_empty(emp), .fifo_full(full),
        .iss_valid(iv), .iss_reg(idst),
        .lop_train(tv), .lop_pc(tpc), .lop_src2_last(tl2),
        .steer_valid(steer_valid), .steer_fifo(steer_fifo), .stall(stall)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FIFO steering FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit usable(input int r);
        return mv[r] && en[mf[r]] && !full[mf[r]];
    endfunction

    function automatic void mpick();
        int a, b;
        bit ha, hb;
        ha = 0; hb = 0; a = 0; b = 0;
        if (!r1 && !r2) begin
            if (mc[d_pc[3:0]] >= 2) begin a = s2; b = s1; end
            else begin a = s1; b = s2; end
            ha = 1; hb = 1;
        end else if (!r1 || !r2) begin
            a = r1 ? s2 : s1; ha = 1;
        end
        m_ok = 1;
        if (ha && usable(a)) m_f = mf[a];
        else if (hb && usable(b)) m_f = mf[b];
        else begin
            m_ok = 0; m_f = 0;
            for (int i = 3; i >= 0; i--)
                if (en[i] && emp[i]) begin m_ok = 1; m_f = i; end
        end
    endfunction

    task automatic rnd(output logic [31:0] v);
        rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
        v = rs;
    endtask

    // one cycle: check before the edge against the model, then advance the model
    task automatic step(input string tag);
        @(negedge clk);
        mpick();
        if (d_valid) begin
            chk(steer_valid == m_ok, {tag, " valid"}, steer_valid, m_ok);
            chk(stall == !m_ok, {tag, " stall"}, stall, !m_ok);
            if (m_ok) chk(steer_fifo == m_f, {tag, " fifo"}, steer_fifo, m_f);
        end else begin
            chk(!steer_valid && !stall, {tag, " R6 idle"}, {steer_valid, stall}, 0);
        end
        @(posedge clk);
        #1;
        if (iv) mv[idst] = 0;
        if (d_valid && m_ok) begin
            for (int r = 0; r < 16; r++) if (mv[r] && mf[r] == m_f) mv[r] = 0;
            mv[dst] = 1; mf[dst] = m_f;
        end
        if (tv) begin
            if (tl2 && mc[tpc[3:0]] < 3) mc[tpc[3:0]]++;
            else if (!tl2 && mc[tpc[3:0]] > 0) mc[tpc[3:0]]--;
        end
        iv = 0; tv = 0;
    endtask

    task automatic offer(input logic [3:0] a, input logic ra, input logic [3:0] b,
                         input logic rb, input logic [3:0] d, input logic [3:0] e);
        d_valid = 1; s1 = a; r1 = ra; s2 = b; r2 = rb; dst = d; emp = e;
    endtask

    initial begin
        #1_500_000;
        bad++; total++;
        $display("FIFO steering FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int r = 0; r < 16; r++) begin mv[r] = 0; mf[r] = 0; mc[r] = 1; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #2 chk(!steer_valid && !stall, "R9 reset outputs", {steer_valid, stall}, 0);
        step("reset idle");

        // R1 / R10: all-ready sweep over every enable and empty mask
        for (int e = 0; e < 16; e++)
            for (int m = 0; m < 16; m++) begin
                en = 4'(e); offer(0, 1, 0, 1, 0, 4'(m));
                step("R1 R10 sweep");
            end

        // R2 / R7 / R8: producer chain
        d_valid = 0; iv = 1; idst = 0; en = 4'hF; step("R8 clear");
        offer(0, 1, 0, 1, 5, 4'hF); step("R1 first");
        offer(5, 0, 0, 1, 6, 4'b1110);
        #1 chk(steer_fifo == 0 && steer_valid, "R2 follow tail", steer_fifo, 0);
        step("R2");
        offer(5, 0, 0, 1, 7, 4'b1110);
        #1 chk(steer_fifo == 1, "R7 old tail dropped", steer_fifo, 1);
        step("R7");
        d_valid = 0; iv = 1; idst = 7; step("R8 issue");
        offer(7, 0, 0, 1, 8, 4'b1100);
        #1 chk(steer_fifo == 2, "R8 issued producer not followed", steer_fifo, 2);
        step("R8");
        offer(0, 1, 6, 0, 4, 4'b1000);
        #1 chk(steer_fifo == 0, "R2 pending on src2", steer_fifo, 0);
        step("R2 src2");

        // R4 / R5 / R9: two pending sources
        offer(0, 1, 0, 1, 1, 4'b0010); step("R4 setup1");
        offer(0, 1, 0, 1, 2, 4'b0100); step("R4 setup2");
        d_pc = 16'h3;
        offer(1, 0, 2, 0, 9, 4'b1000);
        #1 chk(steer_fifo == 1, "R9 R4 default src1 late", steer_fifo, 1);
        step("R4 default");
        d_pc = 0; offer(0, 1, 0, 1, 1, 4'b0010); step("R4 setup3");
        d_valid = 0; tv = 1; tpc = 16'h3; tl2 = 1; step("R9 train1");
        tv = 1; tpc = 16'h3; tl2 = 1; step("R9 train2");
        d_pc = 16'h3;
        offer(1, 0, 2, 0, 9, 4'b1000);
        #1 chk(steer_fifo == 2, "R4 trained src2 late", steer_fifo, 2);
        step("R4 trained");
        offer(1, 0, 2, 0, 10, 4'b1000);
        #1 chk(steer_fifo == 1, "R5 fallback other producer", steer_fifo, 1);
        step("R5 other");
        offer(1, 0, 2, 0, 11, 4'b1000);
        #1 chk(steer_fifo == 3, "R5 fallback empty", steer_fifo, 3);
        step("R5 empty");
        d_pc = 0;

        // R6: stall leaves tables alone
        offer(12, 0, 13, 0, 14, 4'b0000); full = 4'b0100;
        #1 chk(stall && !steer_valid, "R6 stall", {stall, steer_valid}, 2);
        step("R6 stall");
        full = 0; offer(14, 0, 0, 1, 3, 4'b0001);
        #1 chk(steer_fifo == 0, "R6 stalled dst not recorded", steer_fifo, 0);
        step("R6 after");
        offer(10, 0, 0, 1, 12, 4'b0000);
        #1 chk(steer_fifo == 1 && steer_valid, "R6 tail kept across stall", steer_fifo, 1);
        step("R6 kept");

        // R10 / R3: disabled or full producer FIFO
        en = 4'b1101; offer(12, 0, 0, 1, 13, 4'b0011);
        #1 chk(steer_fifo == 0, "R10 disabled producer skipped", steer_fifo, 0);
        step("R10");
        en = 4'hF; full = 4'b0001; offer(13, 0, 0, 1, 15, 4'b1000);
        #1 chk(steer_fifo == 3, "R3 full producer skipped", steer_fifo, 3);
        step("R3");
        full = 0;

        // mixed pseudo-random stream against the model
        for (int n = 0; n < 4000; n++) begin
            rnd(v);
            d_valid = v[1:0] != 0;
            s1 = {1'b0, v[4:2]}; s2 = {1'b0, v[7:5]}; dst = {1'b0, v[10:8]};
            r1 = v[11] & v[12]; r2 = v[13] & v[14];
            en = v[18:15] | 4'b0001 & {4{v[19]}};
            emp = v[23:20] & {4{v[24]}};
            full = v[28:25] & ~emp;
            d_pc = {14'd0, v[30:29]};
            rnd(v);
            iv = v[0] & v[1]; idst = {1'b0, v[4:2]};
            tv = v[5]; tpc = {14'd0, v[7:6]}; tl2 = v[8];
            step("R1 R2 R3 R4 R5 R7 R8 mixed");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule